// File: doc/BRIEF.md
# Next-PC and Exception Return Unit

This block owns the program counter of a 16-bit, byte-addressed processor whose instructions are two bytes long. On every cycle where the pipeline allows progress (`step` high), it picks the address of the next instruction from a decoded control-flow code and some operands. The possible sources are:

- the sequential address;
- a conditional PC-relative branch that tests a register for zero, non-zero or negative;
- an unconditional PC-relative jump;
- a register-plus-offset jump;
- a return through the link register;
- an exception entry;
- an exception return.

The block also presents the link value, which is the address of the following instruction, for a link write. It keeps the saved exception return address, and it holds the processor frozen after a halt.

The decoder in front of the block supplies the flow code, the already sign-extended offset and the operand values. Instruction fetch and the register file sit outside the block. Register-based targets are formed from the operand values sampled in the same cycle. A jump-and-link through the link register therefore uses the old link value.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc`, `epc` and `halted` all become 0 after that edge.
- R2: With `step` low, `pc`, `epc` and `halted` keep their values across the edge, whatever the other inputs are.
- R3: On a step with flow code 0 (sequential), and with neither `halt` nor `illegal` set, `pc` becomes `pc+2`.
- R4: On a step, flow code 1 branches when `rs_val` is zero, code 2 when it is non-zero, and code 3 when its bit 15 is set. A taken branch loads `pc+2+imm`. A branch that is not taken loads `pc+2`.
- R5: Flow code 4 (relative jump, with or without link) loads `pc+2+imm`.
- R6: Flow code 5 (register jump, with or without link) loads `rs_val+imm`.
- R7: Flow code 6 (return) loads `r7_val`.
- R8: Flow code 7 (exception return) loads the current `epc`.
- R9: `link` always equals the current `pc` plus 2, modulo 2^16.
- R10: A step with `halt` set loads `pc+2` and sets `halted`. While `halted` is 1, `pc`, `epc` and `halted` no longer change until reset, even when `step`, `illegal` or a flow code is applied.
- R11: A step with `illegal` set loads `epc` with `pc+2` and `pc` with the vector 0x0002. This takes priority over `halt` and over the flow code, and `halted` stays 0. No other event changes `epc`.
- R12: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the PC this cycle |
| flow | input | 3 | Decoded control-flow code (0..7) |
| rs_val | input | 16 | Source register value |
| r7_val | input | 16 | Link register value |
| imm | input | 16 | Sign-extended offset or displacement |
| halt | input | 1 | Current instruction is a halt |
| illegal | input | 1 | Current instruction raises the illegal-instruction exception |
| pc | output | 16 | Registered program counter |
| link | output | 16 | Return address for a link write (pc+2) |
| epc | output | 16 | Saved exception return address |
| halted | output | 1 | Processor frozen after a halt |

## Verification
The exception entry and the halt can be requested in the same step. The exception can also meet any of the eight flow codes, including a taken branch. The bench raises `illegal` and `halt` together, and `illegal` together with a redirecting flow code. In each case it expects the vector in `pc`, the old `pc+2` in `epc` and `halted` still 0. It then shows that a later halt still freezes the machine, and that an exception requested after the freeze leaves `epc` alone.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int FLOW_W = 3;

  typedef enum logic [FLOW_W-1:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BRZ  = 3'd1,
    FLOW_BRNZ = 3'd2,
    FLOW_BRN  = 3'd3,
    FLOW_JREL = 3'd4,
    FLOW_JREG = 3'd5,
    FLOW_RET  = 3'd6,
    FLOW_ERET = 3'd7
  } flow_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [FLOW_W-1:0] flow,
  input  logic [W-1:0]      rs,
  output logic              redirect
);
  always_comb begin
    unique case (flow_e'(flow))
      FLOW_SEQ:  redirect = 1'b0;
      FLOW_BRZ:  redirect = (rs == '0);
      FLOW_BRNZ: redirect = (rs != '0);
      FLOW_BRN:  redirect = rs[W-1];
      default:   redirect = 1'b1;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [FLOW_W-1:0] flow,
  input  logic [W-1:0]      pc_inc,
  input  logic [W-1:0]      rs,
  input  logic [W-1:0]      r7,
  input  logic [W-1:0]      epc,
  input  logic [W-1:0]      imm,
  output logic [W-1:0]      target
);
  logic [W-1:0] rel_sum;
  logic [W-1:0] reg_sum;

  assign rel_sum = pc_inc + imm;
  assign reg_sum = rs + imm;

  always_comb begin
    unique case (flow_e'(flow))
      FLOW_JREG: target = reg_sum;
      FLOW_RET:  target = r7;
      FLOW_ERET: target = epc;
      default:   target = rel_sum;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          W      = 16,
  parameter int          INSN_B = 2,
  parameter logic [15:0] VECTOR = 16'h0002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FLOW_W-1:0] flow,
  input  logic [W-1:0]      rs_val,
  input  logic [W-1:0]      r7_val,
  input  logic [W-1:0]      imm,
  input  logic              halt,
  input  logic              illegal,
  output logic [W-1:0]      pc,
  output logic [W-1:0]      link,
  output logic [W-1:0]      epc,
  output logic              halted
);
  localparam logic [W-1:0] STRIDE = W'(INSN_B);
  localparam logic [W-1:0] VEC_W  = W'(VECTOR);

  logic [W-1:0] pc_q, epc_q, pc_inc, target;
  logic         halted_q, redirect, advance;

  assign pc_inc  = pc_q + STRIDE;
  assign advance = step && !halted_q;

  npc_cond #(.W(W)) u_cond (
    .flow     (flow),
    .rs       (rs_val),
    .redirect (redirect)
  );

  npc_target #(.W(W)) u_target (
    .flow   (flow),
    .pc_inc (pc_inc),
    .rs     (rs_val),
    .r7     (r7_val),
    .epc    (epc_q),
    .imm    (imm),
    .target (target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      epc_q    <= '0;
      halted_q <= 1'b0;
    end else if (advance) begin
      if (illegal) begin
        epc_q <= pc_inc;
        pc_q  <= VEC_W;
      end else if (halt) begin
        pc_q     <= pc_inc;
        halted_q <= 1'b1;
      end else begin
        pc_q <= redirect ? target : pc_inc;
      end
    end
  end

  assign pc     = pc_q;
  assign epc    = epc_q;
  assign halted = halted_q;
  assign link   = pc_inc;

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(pc_q) && $stable(epc_q) && $stable(halted_q))); // R2
  AST_SEQ_STRIDE: assert property (@(posedge clk) disable iff (rst)
    (advance && !illegal && !halt && flow == FLOW_SEQ) |=> pc_q == $past(pc_q) + STRIDE); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> ($stable(pc_q) && $stable(epc_q) && halted_q)); // R10
  AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (advance && illegal) |=> (pc_q == VEC_W && !halted_q)); // R11
  AST_EPC_ONLY_EXC: assert property (@(posedge clk) disable iff (rst)
    !(advance && illegal) |=> $stable(epc_q)); // R11
  AST_RET_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && !illegal && !halt && flow == FLOW_RET) |=> pc_q == $past(r7_val)); // R7
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst, step, halt, illegal;
  logic [2:0]  flow;
  logic [15:0] rs_val, r7_val, imm;
  logic [15:0] pc, link, epc;
  logic        halted;
  int          checks = 0;
  int          errors = 0;
  logic [15:0] mpc, mepc;
  logic        mhalt;
  logic [15:0] rs_set [5] = '{16'h0000, 16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF};
  logic [15:0] imm_set [3] = '{16'hFFFC, 16'h0006, 16'h0000};

  always #10 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst(rst), .step(step), .flow(flow), .rs_val(rs_val),
    .r7_val(r7_val), .imm(imm), .halt(halt), .illegal(illegal),
    .pc(pc), .link(link), .epc(epc), .halted(halted)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R3";
      3'd1, 3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Reference model applied once per step.
  task automatic model_step();
    logic [15:0] inc;
    logic        take;
    inc = mpc + 16'd2;
    if (rst) begin
      mpc = 0; mepc = 0; mhalt = 0;
    end else if (step && !mhalt) begin
      if (illegal) begin
        mepc = inc; mpc = 16'h0002;
      end else if (halt) begin
        mpc = inc; mhalt = 1'b1;
      end else begin
        case (flow)
          3'd0: take = 1'b0;
          3'd1: take = (rs_val == 16'h0);
          3'd2: take = (rs_val != 16'h0);
          3'd3: take = rs_val[15];
          default: take = 1'b1;
        endcase
        if (!take) mpc = inc;
        else case (flow)
          3'd5: mpc = rs_val + imm;
          3'd6: mpc = r7_val;
          3'd7: mpc = mepc;
          default: mpc = inc + imm;
        endcase
      end
    end
  endtask

  task automatic cycle(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(req, pc, mpc);
    chk("R9", link, mpc + 16'd2);
  endtask

  task automatic setin(input logic s, input logic [2:0] f, input logic [15:0] rs,
                       input logic [15:0] r7, input logic [15:0] im,
                       input logic h, input logic il);
    step = s; flow = f; rs_val = rs; r7_val = r7; imm = im; halt = h; illegal = il;
  endtask

  initial begin
    mpc = 0; mepc = 0; mhalt = 0;
    rst = 1'b1;
    setin(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    cycle("R1");
    rst = 1'b0;
    chk("R1", epc, 16'h0);
    chk("R1", {15'h0, halted}, 16'h0);

    // R2: no step, return requested: nothing moves
    setin(0, 3'd6, 16'h0, 16'h1234, 16'h0, 0, 1);
    cycle("R2");
    chk("R2", epc, 16'h0);

    // R11: exception from pc 0 -> epc 2, pc 2
    setin(1, 3'd0, 16'h0, 16'h0, 16'h0, 0, 1);
    cycle("R11");
    chk("R11", epc, mepc);

    // Sweep of every flow code against operand patterns
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 5; r++)
        for (int i = 0; i < 3; i++) begin
          setin(1, 3'(f), rs_set[r], (mpc ^ 16'h0F0F) & 16'hFFFE, imm_set[i], 0, 0);
          cycle(tag_of(3'(f)));
          chk("R11", epc, 16'h0002);
        end

    // R12: wrap at the top of the address space
    setin(1, 3'd5, 16'hFFF0, 0, 16'h000E, 0, 0);
    cycle("R6");
    chk("R12", pc, 16'hFFFE);
    setin(1, 3'd0, 0, 0, 0, 0, 0);
    cycle("R12");
    chk("R12", pc, 16'h0000);
    setin(1, 3'd4, 0, 0, 16'hFFFC, 0, 0);
    cycle("R12");

    // R11: illegal beats halt and a taken jump in the same step
    setin(1, 3'd4, 0, 0, 16'h0040, 1, 1);
    cycle("R11");
    chk("R11", epc, mepc);
    chk("R11", {15'h0, halted}, 16'h0);
    setin(1, 3'd2, 16'h0005, 0, 16'h0010, 0, 1);
    cycle("R11");
    chk("R11", epc, mepc);

    // R8: return to the stored address
    setin(1, 3'd7, 0, 0, 0, 0, 0);
    cycle("R8");

    // R10: halt, then try to move
    setin(1, 3'd0, 0, 0, 0, 1, 0);
    cycle("R10");
    chk("R10", {15'h0, halted}, 16'h1);
    setin(1, 3'd5, 16'h4000, 0, 16'h0, 0, 0);
    cycle("R10");
    setin(1, 3'd0, 0, 0, 0, 0, 1);
    cycle("R10");
    chk("R10", epc, mepc);
    chk("R10", {15'h0, halted}, 16'h1);

    // R1: reset after halt
    rst = 1'b1;
    cycle("R1");
    rst = 1'b0;
    chk("R1", epc, 16'h0);
    chk("R1", {15'h0, halted}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule